// File: doc/BRIEF.md
# Programmable Fractional Enable Generator

This block produces a single-cycle enable strobe whose long-run rate is a rational fraction of its own clock. The fraction is set at run time through a small Wishbone slave port. It uses an error-accumulating (Bresenham-style) counter. Each clock, the counter adds one of two software-supplied increments, and the carry out of the addition becomes the strobe for the following cycle. For a clock-to-target ratio of `fdr : ftr`, software writes `ftr` as the step increment. It writes `2^CNT_W + ftr - fdr` as the wrap increment. The hardware therefore needs no subtractor, no divider and no gcd logic.

Writing the wrap register restarts the counter, so software writes the step register first and the wrap register last. Writing only the step register changes the rate without a restart. Loading zero into both registers silences the strobe. The bus is control-only, so it uses the plain Wishbone strobe/acknowledge handshake. The single output is a plain level with no back-pressure.

Top module: `frac_enable_gen`

## Requirements
- R1: After a synchronous active-high reset, both increment registers read 0, `enable_o` is low and `wb_ack_o` is low.
- R2: `wb_ack_o` is high for exactly one cycle, in the cycle after each cycle in which `wb_cyc_i` and `wb_stb_i` are high while `wb_ack_o` is low. The master holds the request until it sees the acknowledge.
- R3: Word index 0 on `wb_adr_i` is the step increment and index 1 is the wrap increment. A write stores the low `CNT_W` bits of `wb_dat_i`, and a read returns the stored value zero-extended in `wb_dat_o` while `wb_ack_o` is high. Any other index reads 0, and writes to it change neither register.
- R4: At each clock edge the block adds an increment to its `CNT_W`-bit counter. It adds the wrap increment if `enable_o` is high in that cycle and the step increment otherwise. The carry out of that `CNT_W`-bit sum is `enable_o` for the next cycle.
- R5: A write to the wrap register (index 1) sets the counter to 0 and raises `enable_o` in the cycle after the write's request cycle. This is the cycle in which `wb_ack_o` is high.
- R6: Let `1 <= ftr < fdr <= 2^CNT_W` and wrap = `2^CNT_W + ftr - fdr`. Count the cycle of R5 as k = 0. Then `enable_o` in cycle k equals floor((k+fdr)·ftr/fdr) − floor((k+fdr−1)·ftr/fdr). This gives exactly `ftr` enables in every `fdr` consecutive cycles.
- R7: A write to the step register (index 0) does not restart the counter. The addition at the write's own edge still uses the old value, and every later addition uses the new value.
- R8: When the step register holds 0 and the wrap register is then written with 0, `enable_o` is high in the cycle of R5 only and then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write (1) or read (0) |
| wb_adr_i | input | ADR_W | Word index of the register |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid while `wb_ack_o` is high |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| enable_o | output | 1 | Fractional-rate enable strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 32-bit data bus and a 4-bit word index. Because the counter is only 8 bits, every ratio window is at most 256 cycles long. Random ratios across the whole legal range can then be checked cycle by cycle over two full periods each, alongside the corner ratios. The corners are 1:2, 255:256 and 1:256, and the power-of-two denominator where the wrap and step increments are equal. The 32-bit bus places upper data bits beyond the counter width, so truncation on write and zero-extension on read are both observable.

// File: rtl/frac_enable_pkg.sv
package frac_enable_pkg;
  localparam int unsigned IDX_STEP = 0;
  localparam int unsigned IDX_WRAP = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STEP = 2'd1,
    SEL_WRAP = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/frac_enable_regs.sv
module frac_enable_regs
  import frac_enable_pkg::*;
#(
  parameter int unsigned ADR_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o,
  output logic [CNT_W-1:0]  step_o,
  output logic [CNT_W-1:0]  wrap_o,
  output logic              restart_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic             ack_q;
  logic             accept;
  reg_sel_e         sel;
  logic [CNT_W-1:0] step_q, wrap_q, rd_val;
  logic [DATA_W-1:0] rd_ext, dat_q;

  assign accept = cyc_i && stb_i && !ack_q;

  always_comb begin
    if (adr_i == ADR_W'(IDX_STEP))      sel = SEL_STEP;
    else if (adr_i == ADR_W'(IDX_WRAP)) sel = SEL_WRAP;
    else                                sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_STEP: rd_val = step_q;
      SEL_WRAP: rd_val = wrap_q;
      default:  rd_val = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_ext = {{PAD_W{1'b0}}, rd_val};
    end else begin : g_nopad
      assign rd_ext = rd_val[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_q  <= 1'b0;
      step_q <= '0;
      wrap_q <= '0;
      dat_q  <= '0;
    end else begin
      ack_q <= accept;
      if (accept && we_i && sel == SEL_STEP) step_q <= dat_i[CNT_W-1:0];
      if (accept && we_i && sel == SEL_WRAP) wrap_q <= dat_i[CNT_W-1:0];
      if (accept && !we_i) dat_q <= rd_ext;
    end
  end

  assign restart_o = accept && we_i && (sel == SEL_WRAP);
  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign step_o = step_q;
  assign wrap_o = wrap_q;

  assert_ack_follows_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i && !ack_o) |=> ack_o);
  assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);
  assert_unmapped_write_ignored_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i && !ack_o && we_i && adr_i > ADR_W'(IDX_WRAP))
      |=> ($stable(step_o) && $stable(wrap_o)));
endmodule

// File: rtl/frac_enable_accum.sv
module frac_enable_accum #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [CNT_W-1:0] wrap_i,
  input  logic             restart_i,
  output logic             enable_o
);
  logic [CNT_W-1:0] acc_q;
  logic             carry_q;
  logic [CNT_W-1:0] addend;
  logic [CNT_W:0]   sum;

  assign addend = carry_q ? wrap_i : step_i;
  assign sum    = {1'b0, acc_q} + {1'b0, addend};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (restart_i) begin
      acc_q   <= '0;
      carry_q <= 1'b1;
    end else begin
      acc_q   <= sum[CNT_W-1:0];
      carry_q <= sum[CNT_W];
    end
  end

  assign enable_o = carry_q;

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> !enable_o);
  assert_restart_state_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (enable_o && acc_q == '0));
  assert_zero_step_silent_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!restart_i && !enable_o && step_i == '0) |=> !enable_o);
  assert_carry_leaves_below_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!restart_i && enable_o && wrap_i == '0) |=> !enable_o);
endmodule

// File: rtl/frac_enable_gen.sv
module frac_enable_gen #(
  parameter int unsigned ADR_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADR_W-1:0]  wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              enable_o
);
  logic [CNT_W-1:0] step_w, wrap_w;
  logic             restart_w;

  frac_enable_regs #(.ADR_W(ADR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cyc_i     (wb_cyc_i),
    .stb_i     (wb_stb_i),
    .we_i      (wb_we_i),
    .adr_i     (wb_adr_i),
    .dat_i     (wb_dat_i),
    .dat_o     (wb_dat_o),
    .ack_o     (wb_ack_o),
    .step_o    (step_w),
    .wrap_o    (wrap_w),
    .restart_o (restart_w)
  );

  frac_enable_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .step_i    (step_w),
    .wrap_i    (wrap_w),
    .restart_i (restart_w),
    .enable_o  (enable_o)
  );
endmodule

// File: tb/test_frac_enable_gen.sv
`timescale 1ns/1ps
module test_frac_enable_gen;
  localparam int ADR_W = 4, DATA_W = 32, CNT_W = 8;
  localparam int MODW = 1 << CNT_W;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [ADR_W-1:0]  adr = '0;
  logic [DATA_W-1:0] dat_i = '0;
  logic [DATA_W-1:0] dat_o;
  logic ack, en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frac_enable_gen #(.ADR_W(ADR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_frac_enable_gen (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack), .enable_o(en));

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic bit exp_en(input int k, input int ftr, input int fdr);
    return (((k + fdr) * ftr) / fdr) != (((k + fdr - 1) * ftr) / fdr);
  endfunction

  // returns at the negedge of the ack cycle (k = 0 for a wrap write)
  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a[ADR_W-1:0]; dat_i = d;
    @(negedge clk);
    chk(ack == 1'b1, "R2 write ack", ack, 1);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a[ADR_W-1:0];
    @(negedge clk);
    chk(ack == 1'b1, "R2 read ack", ack, 1);
    d = dat_o;
    cyc = 0; stb = 0;
    @(negedge clk);
    chk(ack == 1'b0, "R2 ack single cycle", ack, 0);
  endtask

  // program ratio, then check 2*fdr cycles plus per-window count
  task automatic run_ratio(input int ftr, input int fdr);
    int cnt = 0;
    bus_write(0, ftr);
    bus_write(1, MODW + ftr - fdr);
    for (int k = 0; k < 2 * fdr; k++) begin
      if (k > 0) @(negedge clk);
      chk(en == exp_en(k, ftr, fdr), $sformatf("R4 R6 en k=%0d ftr=%0d fdr=%0d", k, ftr, fdr),
          en, exp_en(k, ftr, fdr));
      if (k < fdr && en) cnt++;
    end
    chk(cnt == ftr, "R6 enables per window", cnt, ftr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int ftr, fdr;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(en == 1'b0, "R1 enable after reset", en, 0);
    chk(ack == 1'b0, "R1 ack after reset", ack, 0);
    bus_read(0, rd); chk(rd == 0, "R1 step reg reset", rd, 0);
    bus_read(1, rd); chk(rd == 0, "R1 wrap reg reset", rd, 0);
    repeat (10) begin @(negedge clk); chk(en == 1'b0, "R1 idle after reset", en, 0); end

    // R3 map, truncation, zero-extension, unmapped index
    bus_write(0, 32'hABCD_EF12);
    bus_read(0, rd); chk(rd == 32'h12, "R3 step readback", rd, 32'h12);
    bus_write(5, 32'h0000_0077);
    bus_read(5, rd); chk(rd == 0, "R3 unmapped read", rd, 0);
    bus_read(0, rd); chk(rd == 32'h12, "R3 unmapped write ignored step", rd, 32'h12);
    bus_read(1, rd); chk(rd == 0, "R3 unmapped write ignored wrap", rd, 0);
    bus_write(0, 0);

    // R5 / R6 directed corners
    run_ratio(3, 8);
    run_ratio(1, 2);
    run_ratio(255, 256);
    run_ratio(1, 256);
    run_ratio(64, 256);
    bus_read(1, rd); chk(rd == 64, "R3 wrap readback", rd, 64);

    // R7 same-value step write does not restart
    bus_write(0, 3);
    bus_write(1, MODW + 3 - 8);
    chk(en == 1'b1, "R5 enable after wrap write", en, 1);
    bus_write(0, 3);
    for (int k = 2; k < 20; k++) begin
      if (k > 2) @(negedge clk);
      chk(en == exp_en(k, 3, 8), $sformatf("R7 no restart k=%0d", k), en, exp_en(k, 3, 8));
    end
    // R7 new step value used after its own edge
    bus_write(1, MODW + 3 - 8);
    bus_write(0, 0);
    for (int k = 2; k < 40; k++) begin
      if (k > 2) @(negedge clk);
      chk(en == 1'b0, $sformatf("R7 zero step takes effect k=%0d", k), en, 0);
    end

    // R8 zero/zero
    bus_write(1, 0);
    chk(en == 1'b1, "R8 single pulse", en, 1);
    repeat (40) begin @(negedge clk); chk(en == 1'b0, "R8 silent after zeros", en, 0); end

    // random ratios
    repeat (40) begin
      fdr = 2 + int'($urandom % 255);
      ftr = 1 + int'($urandom % (fdr - 1));
      run_ratio(ftr, fdr);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule